// File: doc/BRIEF.md
# Ratio-Aware Launch Enable Generator

This block sits in the faster of two clock domains that share one clock root and a known phase relationship. It drives an enable for the source registers whose outputs cross into the slower domain. The enable is dropped on any fast edge that falls too close to the next slow capture edge. With a non-integer ratio, one fast edge falls only half a fast period before a slow edge. A launch there could let a glitch from the crossing logic settle late and be sampled, so the enable is held low for that edge. Every launch the block permits therefore has at least one full fast period of setup before capture.

The block is told about the clock relationship in two ways. A ratio-select input picks 1:1, 2:1 or 3:2. A single-cycle alignment pulse, sampled at a fast edge, announces that the following fast edge coincides with a slow edge. The block keeps a phase counter in the fast domain. `phase_idx` names the phase of the next fast edge, which is the edge at which the current value of `launch_en` takes effect. The ratio is loaded only at an alignment pulse. Until the first pulse the phase is unknown, so no launch is allowed.

Top module: `launch_enable_gen`

## Requirements
- R1: While `rst_n` is low, `launch_en` is 0 and `phase_idx` is 0.
- R2: After reset, `launch_en` stays 0 until an alignment pulse has been sampled, whatever `ratio_sel` holds.
- R3: In the cycle after an edge where `align_pulse` is sampled high, `phase_idx` is 0, meaning the next fast edge coincides with a slow edge.
- R4: Without a pulse, `phase_idx` advances by one per fast cycle and wraps to 0 at the period of the active ratio: 1 for codes 0 and 3, 2 for code 1 and 3 for code 2.
- R5: With ratio code 2 (3:2) active, `launch_en` is 0 when `phase_idx` is 1 and 1 when `phase_idx` is 0 or 2.
- R6: With ratio code 0 (1:1), code 1 (2:1) or the spare code 3 (treated as 1:1) active, `launch_en` is 1 in every cycle once aligned.
- R7: `ratio_sel` is loaded only at an alignment pulse. Changing it at any other time has no effect on `launch_en` or `phase_idx`.
- R8: For every active ratio, a launch at the next fast edge is enabled exactly when that edge is at least one fast period before the next slow edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Ratio code: 0 = 1:1, 1 = 2:1, 2 = 3:2, 3 = treated as 1:1 |
| align_pulse | input | 1 | High for one cycle: the next fast edge is coincident with a slow edge |
| launch_en | output | 1 | Enable for the source registers at the next fast edge |
| phase_idx | output | 2 | Phase of the next fast edge within the ratio period |

## Verification
A wrong phase count or a wrongly held ratio shows up in the first cycle after the bad state forms. `phase_idx` leaves the expected sequence, or `launch_en` drops on an edge that has a full period of margin, or rises on the half-period edge. The bench places an arithmetic slow clock against each aligned sequence, so an over-eager or over-cautious enable is reported at the launch it affects. A ratio that was loaded without a pulse shows within one period as the wrong wrap point.

// File: rtl/lenab_pkg.sv
package lenab_pkg;
  localparam int RATIO_W = 2;
  localparam int PHASE_W = 2;

  typedef enum logic [RATIO_W-1:0] {
    RATIO_1TO1 = 2'd0,
    RATIO_2TO1 = 2'd1,
    RATIO_3TO2 = 2'd2,
    RATIO_SPARE = 2'd3
  } ratio_e;

  // Number of fast edges before the alignment pattern repeats.
  function automatic logic [PHASE_W-1:0] phase_period(input ratio_e r);
    case (r)
      RATIO_2TO1: phase_period = PHASE_W'(2);
      RATIO_3TO2: phase_period = PHASE_W'(3);
      default:    phase_period = PHASE_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/lenab_ratio_hold.sv
module lenab_ratio_hold
  import lenab_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  ratio_e ratio_in,
  output ratio_e ratio_q,
  output logic   synced_q
);
  ratio_e ratio_d;
  logic   synced_d;

  always_comb begin
    ratio_d  = ratio_q;
    synced_d = synced_q;
    if (load) begin
      ratio_d  = ratio_in;
      synced_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q  <= RATIO_1TO1;
      synced_q <= 1'b0;
    end else if (load) begin
      ratio_q  <= ratio_d;
      synced_q <= synced_d;
    end
  end
endmodule

// File: rtl/lenab_phase_ctr.sv
module lenab_phase_ctr
  import lenab_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               run,
  input  ratio_e             ratio,
  output logic [PHASE_W-1:0] phase_q
);
  logic [PHASE_W-1:0] phase_d;
  logic [PHASE_W-1:0] phase_inc;
  logic               phase_ce;

  assign phase_inc = phase_q + PHASE_W'(1);
  assign phase_ce  = restart | run;

  always_comb begin
    if (restart)
      phase_d = '0;
    else if (phase_inc >= phase_period(ratio))
      phase_d = '0;
    else
      phase_d = phase_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (phase_ce)
      phase_q <= phase_d;
  end
endmodule

// File: rtl/lenab_gate_decode.sv
module lenab_gate_decode
  import lenab_pkg::*;
#(
  parameter int unsigned HALF_PHASE = 1
) (
  input  logic               synced,
  input  ratio_e             ratio,
  input  logic [PHASE_W-1:0] phase,
  output logic               enable
);
  logic short_edge;

  assign short_edge = (ratio == RATIO_3TO2) && (phase == PHASE_W'(HALF_PHASE));
  assign enable     = synced && !short_edge;
endmodule

// File: rtl/launch_enable_gen.sv
module launch_enable_gen
  import lenab_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_sel,
  input  logic               align_pulse,
  output logic               launch_en,
  output logic [PHASE_W-1:0] phase_idx
);
  ratio_e             act_ratio;
  logic               synced;
  logic [PHASE_W-1:0] phase;

  lenab_ratio_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (align_pulse),
    .ratio_in (ratio_e'(ratio_sel)),
    .ratio_q  (act_ratio),
    .synced_q (synced)
  );

  lenab_phase_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (align_pulse),
    .run     (synced),
    .ratio   (act_ratio),
    .phase_q (phase)
  );

  lenab_gate_decode #(.HALF_PHASE(1)) u_dec (
    .synced (synced),
    .ratio  (act_ratio),
    .phase  (phase),
    .enable (launch_en)
  );

  assign phase_idx = phase;
endmodule

// File: rtl/launch_enable_gen_chk.sv
module launch_enable_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       align_pulse,
  input logic       launch_en,
  input logic [1:0] phase_idx,
  input logic [1:0] act_ratio,
  input logic       synced
);
  assert_reset_state_R1: assert property (@(posedge clk) !rst_n |-> !launch_en && phase_idx == 2'd0);

  assert_no_launch_unsynced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !launch_en);

  assert_align_zero_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    align_pulse |=> phase_idx == 2'd0);

  assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ratio == 2'd2) ? (phase_idx < 2'd3) :
    (act_ratio == 2'd1) ? (phase_idx < 2'd2) : (phase_idx == 2'd0));

  assert_half_edge_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ratio == 2'd2 && phase_idx == 2'd1) |-> !launch_en);

  assert_ratio_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !align_pulse |=> $stable(act_ratio));
endmodule

bind launch_enable_gen launch_enable_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .align_pulse (align_pulse),
  .launch_en   (launch_en),
  .phase_idx   (phase_idx),
  .act_ratio   (act_ratio),
  .synced      (synced)
);

// File: tb/tb_launch_enable_gen.sv
module tb_launch_enable_gen;
  logic       clk;
  logic       rst_n;
  logic [1:0] ratio_sel;
  logic       align_pulse;
  logic       launch_en;
  logic [1:0] phase_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference state derived from the requirements
  bit m_synced;
  int m_ratio;
  int m_phase;

  launch_enable_gen dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_sel   (ratio_sel),
    .align_pulse (align_pulse),
    .launch_en   (launch_en),
    .phase_idx   (phase_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int period_of(int r);
    if (r == 1) return 2;
    if (r == 2) return 3;
    return 1;
  endfunction

  // Slow period in half fast periods; the slow edge sits on phase 0.
  function automatic int slow_half(int r);
    if (r == 1) return 4;
    if (r == 2) return 3;
    return 2;
  endfunction

  // Margin, in half fast periods, from a launch at phase p to the next slow edge.
  function automatic int margin_half(int r, int p);
    int s;
    int t;
    s = slow_half(r);
    t = 2 * p;
    return s * (t / s + 1) - t;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      m_synced = 0; m_ratio = 0; m_phase = 0;
    end else if (align_pulse) begin
      m_synced = 1; m_ratio = ratio_sel; m_phase = 0;
    end else if (m_synced) begin
      m_phase = (m_phase + 1) % period_of(m_ratio);
    end
    @(negedge clk);
  endtask

  task automatic check_state(input bit is_align_next);
    int exp_en;
    if (is_align_next) chk("R3 phase after align", phase_idx, 0);
    else chk("R4 phase", phase_idx, m_phase);
    if (!m_synced) chk("R2 enable before align", launch_en, 0);
    else if (m_ratio == 2) begin
      exp_en = (m_phase == 1) ? 0 : 1;
      chk("R5 enable in 3:2", launch_en, exp_en);
    end else chk("R6 enable in integer ratio", launch_en, 1);
    if (m_synced) begin
      exp_en = (margin_half(m_ratio, m_phase) >= 2) ? 1 : 0;
      chk("R8 launch margin vs slow edge", launch_en, exp_en);
    end
  endtask

  task automatic pulse_align(input int r);
    ratio_sel   = r[1:0];
    align_pulse = 1'b1;
    tick();
    align_pulse = 1'b0;
    check_state(1);
  endtask

  initial begin
    rst_n = 1'b0; ratio_sel = 2'd2; align_pulse = 1'b0;
    m_synced = 0; m_ratio = 0; m_phase = 0;
    tick(); tick();
    chk("R1 reset enable", launch_en, 0);
    chk("R1 reset phase", phase_idx, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ratio_sel = i[1:0];
      tick();
      chk("R2 no launch before align", launch_en, 0);
    end
    for (int r = 0; r < 4; r++) begin
      pulse_align(r);
      for (int c = 0; c < 12; c++) begin
        tick();
        check_state(0);
      end
    end
    // R7: 3:2 active, ratio_sel changes without a pulse
    pulse_align(2);
    for (int c = 0; c < 9; c++) begin
      ratio_sel = c[1:0] ^ 2'd1;
      tick();
      check_state(0);
    end
    chk("R7 ratio held without pulse (phase still cycles 3)", m_ratio, 2);
    // R3: realign in the middle of the sequence at phase 1
    pulse_align(2);
    tick();
    chk("R5 half edge before realign", launch_en, 0);
    pulse_align(2);
    pulse_align(2);
    for (int c = 0; c < 4; c++) begin
      tick();
      check_state(0);
    end
    // Switch 3:2 -> 2:1 at a pulse
    pulse_align(1);
    for (int c = 0; c < 4; c++) begin
      tick();
      check_state(0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule